// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This controller runs a three-wire serial EEPROM (select, shift clock, serial data toward the memory, serial data back) on behalf of a simple request port. A client presents an operation code, a word address and, for writes, a 16-bit word. When the operation ends, the block returns a one-cycle response that carries the word read back and a flag that says whether the memory failed to report ready in time.

Every frame begins with a start bit and a two-bit command code, followed by the address. Writes then add the data word. The shift clock is derived from the system clock through a divider whose value comes in on a port. Writes and erases end with a short drop of the select line, after which the block waits on the data line from the memory until it goes high or until a tick budget runs out. Memories differ in address width, either 6 or 8 bits. A probe operation reads word 0 with a 6-bit address and picks the long width when the result is all ones. All later frames use the width that the probe chose.

Top module: `sprom_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `ee_cs`, `ee_sk`, `ee_di` and `rsp_valid` are 0, and `addr_long` equals the parameter `ADDR_LONG_INIT` (0 by default).
- R2: Request codes on `req_op` are 0 read, 1 write, 2 erase, 3 write-enable and 4 probe. Any other code behaves as a read. The first bit of every frame is a 1. The command code follows it MSB first (read 10, write 01, erase 11, write-enable 00), then the address MSB first. `ee_di` never changes on a cycle where `ee_sk` rises.
- R3: A read clocks in 16 bits MSB first. Each bit is taken from `ee_do` at the end of a shift-clock high phase. The word appears on `rsp_rdata` with the response.
- R4: A write sends the 16-bit word MSB first after the address. It then drops `ee_cs` for one tick, raises it again and samples `ee_do` once per tick. The first 1 ends the operation with `rsp_timeout` = 0.
- R5: If `ee_do` stays 0 for `POLL_TICKS`+1 polled ticks, the write or erase ends with `rsp_timeout` = 1.
- R6: An erase sends its address with no data and then waits for ready in the same way as a write.
- R7: A write-enable sends an address field made entirely of ones, does not wait for ready, and ends with `rsp_timeout` = 0.
- R8: A write issued without an earlier write-enable is still shifted out in full and answered normally. The memory keeps its old word.
- R9: A probe reads word 0 with a 6-bit address. `addr_long` becomes 1 if the result is 0xFFFF and 0 otherwise. All later non-probe frames carry 8 address bits when `addr_long` is 1 and 6 bits when it is 0.
- R10: The shift clock has a period of 2*(`sk_div`+1) system cycles. `ee_sk` is high only while `ee_cs` is high. `ee_cs` is low when the response appears and stays low for at least one tick before the next frame.
- R11: `req_ready` is 0 from the cycle after a request is accepted until that operation's response. A request presented during that time is ignored.
- R12: Every accepted request produces exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_LONG | Word address |
| req_wdata | input | DATA_W | Word to write |
| sk_div | input | DIV_W | Shift-clock divider: half period is sk_div+1 cycles |
| req_ready | output | 1 | Block idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Word read (read and probe) |
| rsp_timeout | output | 1 | Ready wait ran out |
| addr_long | output | 1 | Current address width: 1 = 8 bits, 0 = 6 bits |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The hardest case to reach is a probe against a memory that expects 8 address bits. There, the block's 16 input clocks partly land in the memory's own address phase, so the all-ones result depends on how the memory drives its output line while it is still receiving. The bench's memory model takes its address width as a variable and holds its output high until it starts to drive data. The model is switched from 6 to 8 bits in the middle of the run, and word 0 is set to all ones before the second probe. The ready-timeout is reached by holding the model's output low through the wait, with a small `POLL_TICKS` override. The ignored request is injected while a read is still shifting.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_WREN  = 3'd3;
  localparam logic [2:0] OP_PROBE = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_TX, S_RX, S_GAP, S_POLL, S_END
  } sprom_state_e;

  function automatic logic [1:0] cmd_code(input logic [2:0] op);
    case (op)
      OP_WRITE: cmd_code = 2'b01;
      OP_ERASE: cmd_code = 2'b11;
      OP_WREN:  cmd_code = 2'b00;
      default:  cmd_code = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/sprom_tick.sv
module sprom_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sprom_poll.sv
module sprom_poll #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign expired = (cnt == W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (step && !expired)  cnt <= cnt + 1'b1;
  end

  // R5
  poll_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired || $past(clr));
endmodule

// File: rtl/sprom_ctrl.sv
module sprom_ctrl
  import sprom_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int ADDR_SHORT     = 6,
  parameter int ADDR_LONG      = 8,
  parameter int DIV_W          = 8,
  parameter int POLL_TICKS     = 100000,
  parameter bit ADDR_LONG_INIT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic [ADDR_LONG-1:0] req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DIV_W-1:0]     sk_div,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_timeout,
  output logic                 addr_long,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do
);
  localparam int HDR_W   = 3;
  localparam int FRAME_W = HDR_W + ADDR_LONG + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  sprom_state_e          st;
  logic [FRAME_W-1:0]    frame, frame_new;
  logic [CNT_W-1:0]      left, len_new;
  logic [DATA_W-1:0]     rsh;
  logic [2:0]            op_q;
  logic                  tmo;
  logic                  tick, expired, use_long;
  logic [ADDR_LONG-1:0]  addr_v;
  logic                  is_write, is_erase, is_wren;

  assign is_write = (op_q == OP_WRITE);
  assign is_erase = (op_q == OP_ERASE);
  assign is_wren  = (op_q == OP_WREN);

  sprom_tick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .run ((st != S_IDLE) && (st != S_END)),
    .div (sk_div),
    .tick(tick)
  );

  sprom_poll #(.LIMIT(POLL_TICKS)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .clr    (st != S_POLL),
    .step   (tick && (st == S_POLL) && !ee_do),
    .expired(expired)
  );

  // Frame image, left-aligned: start bit, command code, address, data.
  always_comb begin
    use_long  = addr_long && (req_op != OP_PROBE);
    if (req_op == OP_WREN)       addr_v = '1;
    else if (req_op == OP_PROBE) addr_v = '0;
    else                         addr_v = req_addr;
    frame_new = '0;
    frame_new[FRAME_W-1 -: HDR_W] = {1'b1, cmd_code(req_op)};
    if (use_long) begin
      frame_new[FRAME_W-HDR_W-1 -: ADDR_LONG] = addr_v;
      frame_new[FRAME_W-HDR_W-ADDR_LONG-1 -: DATA_W] = req_wdata;
    end else begin
      frame_new[FRAME_W-HDR_W-1 -: ADDR_SHORT] = addr_v[ADDR_SHORT-1:0];
      frame_new[FRAME_W-HDR_W-ADDR_SHORT-1 -: DATA_W] = req_wdata;
    end
    len_new = CNT_W'(HDR_W + (use_long ? ADDR_LONG : ADDR_SHORT)
                     + ((req_op == OP_WRITE) ? DATA_W : 0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      req_ready   <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
      addr_long   <= ADDR_LONG_INIT;
      ee_cs       <= 1'b0;
      ee_sk       <= 1'b0;
      ee_di       <= 1'b0;
      frame       <= '0;
      left        <= '0;
      rsh         <= '0;
      op_q        <= '0;
      tmo         <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q      <= req_op;
          frame     <= frame_new;
          left      <= len_new;
          rsh       <= '0;
          tmo       <= 1'b0;
          req_ready <= 1'b0;
          st        <= S_SEL;
        end
        S_SEL: if (tick) begin
          ee_cs <= 1'b1;
          ee_di <= frame[FRAME_W-1];
          st    <= S_TX;
        end
        S_TX: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
          end else begin
            ee_sk <= 1'b0;
            frame <= frame << 1;
            ee_di <= frame[FRAME_W-2];
            left  <= left - 1'b1;
            if (left == CNT_W'(1)) begin
              ee_di <= 1'b0;
              if (is_write || is_erase) begin
                ee_cs <= 1'b0;
                st    <= S_GAP;
              end else if (is_wren) begin
                st <= S_END;
              end else begin
                left <= CNT_W'(DATA_W);
                st   <= S_RX;
              end
            end
          end
        end
        S_RX: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
          end else begin
            ee_sk <= 1'b0;
            rsh   <= {rsh[DATA_W-2:0], ee_do};
            left  <= left - 1'b1;
            if (left == CNT_W'(1)) st <= S_END;
          end
        end
        S_GAP: if (tick) begin
          ee_cs <= 1'b1;
          st    <= S_POLL;
        end
        S_POLL: if (tick) begin
          if (ee_do) begin
            st <= S_END;
          end else if (expired) begin
            tmo <= 1'b1;
            st  <= S_END;
          end
        end
        default: begin
          ee_cs       <= 1'b0;
          ee_sk       <= 1'b0;
          ee_di       <= 1'b0;
          rsp_valid   <= 1'b1;
          rsp_rdata   <= rsh;
          rsp_timeout <= tmo;
          if (op_q == OP_PROBE) addr_long <= &rsh;
          req_ready   <= 1'b1;
          st          <= S_IDLE;
        end
      endcase
    end
  end

  // R10
  sk_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs);
  // R2
  di_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sk) |-> $stable(ee_di));
  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R11
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  cs_released_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !ee_cs);
endmodule

// File: tb/sprom_ctrl_test.sv
`timescale 1ns/1ps
module sprom_ctrl_test;
  localparam int BUSY_CYC = 30;
  localparam int MS_IDLE = 0, MS_CMD = 1, MS_WD = 2, MS_OUT = 3,
                 MS_WDONE = 4, MS_EDONE = 5, MS_END = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0] sk_div = 8'd2;
  logic req_ready, rsp_valid, rsp_timeout, addr_long, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rsp_rdata;

  always #5 clk = ~clk;

  sprom_ctrl #(.POLL_TICKS(40)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .sk_div(sk_div),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .addr_long(addr_long), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  int total = 0, failed = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [256];
  int  model_al = 6;
  bit  wen = 0, hang = 0, fresh = 1, first_bit = 0, obegun = 0;
  int  mst = MS_IDLE, nb = 0, sh = 0, maddr = 0, busy = 0;
  int  last_opc = -1, last_addr = -1;
  logic [15:0] wbuf = '0, obuf = '0;
  logic obit = 1'b1, dout = 1'b1, cs_prev = 1'b0, sk_prev = 1'b0;
  int  cyc = 0, rise_prev = 0, rise_last = 0;
  assign ee_do = dout;

  always @(posedge clk) begin
    cyc++;
    if (busy > 0) busy--;
    if (!ee_cs) begin
      if (cs_prev) begin
        if (mst == MS_WDONE && wen) begin mem[maddr] = wbuf; busy = BUSY_CYC; end
        if (mst == MS_EDONE && wen) begin mem[maddr] = 16'hFFFF; busy = BUSY_CYC; end
      end
      mst = MS_IDLE; nb = 0; sh = 0; obegun = 0; fresh = 1;
    end else if (ee_sk && !sk_prev) begin
      rise_prev = rise_last; rise_last = cyc;
      if (fresh) begin first_bit = ee_di; fresh = 0; end
      case (mst)
        MS_IDLE: if (ee_di) begin mst = MS_CMD; nb = 0; sh = 0; end
        MS_CMD: begin
          sh = (sh << 1) | int'(ee_di);
          nb++;
          if (nb == 2 + model_al) begin
            last_opc = (sh >> model_al) & 3;
            maddr = sh & ((1 << model_al) - 1);
            last_addr = maddr;
            case (last_opc)
              2: begin mst = MS_OUT; obuf = mem[maddr]; end
              1: begin mst = MS_WD; nb = 0; end
              3: mst = MS_EDONE;
              default: begin wen = 1; mst = MS_END; end
            endcase
          end
        end
        MS_WD: begin
          wbuf = {wbuf[14:0], ee_di};
          nb++;
          if (nb == 16) mst = MS_WDONE;
        end
        MS_OUT: begin obit = obuf[15]; obuf = obuf << 1; obegun = 1; end
        default: ;
      endcase
    end
    cs_prev = ee_cs; sk_prev = ee_sk;
    if (!ee_cs) dout = 1'b1;
    else if (mst == MS_OUT && obegun) dout = obit;
    else if (mst == MS_IDLE && (hang || busy > 0)) dout = 1'b0;
    else dout = 1'b1;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [15:0] rd; bit chk_rd; bit to; string tag; } exp_t;
  exp_t q[$];
  int pushed = 0, seen = 0;
  logic rsp_prev = 1'b0;

  always @(negedge clk) begin
    if (rsp_valid) begin
      seen++;
      check(!rsp_prev, "R12 pulse width", 32'(rsp_prev), 0);
      if (q.size() == 0) begin
        check(0, "R12 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_rd) check(rsp_rdata == e.rd, e.tag, 32'(rsp_rdata), 32'(e.rd));
        check(rsp_timeout == e.to, {e.tag, " timeout flag"}, 32'(rsp_timeout), 32'(e.to));
      end
    end
    rsp_prev = rsp_valid;
  end

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd,
                       input logic [15:0] er, input bit chk, input bit to, input string tag);
    exp_t e;
    e.rd = er; e.chk_rd = chk; e.to = to; e.tag = tag;
    q.push_back(e);
    pushed++;
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_op;
    while (seen < pushed) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(input logic [2:0] o, input logic [7:0] a, input logic [15:0] wd,
                    input logic [15:0] er, input bit chk, input bit to, input string tag);
    issue(o, a, wd, er, chk, to, tag);
    finish_op();
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(16'h1234 + i * 16'h0111);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    check({ee_cs, ee_sk, ee_di} == 3'b000, "R1 pins idle", 32'({ee_cs, ee_sk, ee_di}), 0);
    check(rsp_valid == 1'b0 && addr_long == 1'b0, "R1 rsp/width", 32'({rsp_valid, addr_long}), 0);

    // R8 write without enable: done normally, memory unchanged
    op(3'd1, 8'd5, 16'hBEEF, 16'h0, 0, 0, "R8 write no enable");
    check(last_opc == 1, "R8 write shifted out", 32'(last_opc), 1);
    op(3'd0, 8'd5, 16'h0, 16'(16'h1234 + 5 * 16'h0111), 1, 0, "R8 read unchanged");

    // R7 write-enable, R2 framing
    op(3'd3, 8'd0, 16'h0, 16'h0, 0, 0, "R7 write enable");
    check(last_opc == 0, "R2 enable code", 32'(last_opc), 0);
    check(((last_addr >> 4) & 3) == 3, "R7 address ones", 32'(last_addr), 32'h3F);
    check(first_bit == 1'b1, "R2 start bit", 32'(first_bit), 1);
    check(wen == 1'b1, "R7 enable seen", 32'(wen), 1);

    // R4 write then R3 read back
    op(3'd1, 8'd5, 16'hBEEF, 16'h0, 0, 0, "R4 write");
    check(mem[5] == 16'hBEEF, "R4 word stored", 32'(mem[5]), 32'hBEEF);
    op(3'd0, 8'd5, 16'h0, 16'hBEEF, 1, 0, "R3 read");
    check(last_opc == 2 && last_addr == 5, "R2 read code/address", 32'({last_opc[7:0], last_addr[7:0]}), 32'h0205);

    // R6 erase
    op(3'd2, 8'd6, 16'h0, 16'h0, 0, 0, "R6 erase");
    op(3'd0, 8'd6, 16'h0, 16'hFFFF, 1, 0, "R6 read erased");

    // R10 shift-clock period with another divider
    sk_div = 8'd3;
    op(3'd0, 8'd63, 16'h0, 16'(16'h1234 + 63 * 16'h0111), 1, 0, "R3 read top");
    check(rise_last - rise_prev == 8, "R10 sk period", 32'(rise_last - rise_prev), 8);
    sk_div = 8'd2;

    // R11 request during busy is ignored
    issue(3'd0, 8'd5, 16'h0, 16'hBEEF, 1, 0, "R11 read during stray");
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R11 ready low busy", 32'(req_ready), 0);
    req_op = 3'd1; req_addr = 8'd5; req_wdata = 16'h0000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_op();
    repeat (40) @(negedge clk);
    check(seen == pushed, "R11 no extra response", 32'(seen), 32'(pushed));
    op(3'd0, 8'd5, 16'h0, 16'hBEEF, 1, 0, "R11 word kept");

    // R5 timeout
    hang = 1;
    op(3'd1, 8'd7, 16'h0707, 16'h0, 0, 1, "R5 timeout");
    hang = 0;
    repeat (BUSY_CYC + 2) @(negedge clk);

    // R9 probe on 6-bit memory
    op(3'd4, 8'd0, 16'h0, 16'h1234, 1, 0, "R9 probe short");
    check(addr_long == 1'b0, "R9 stays short", 32'(addr_long), 0);
    // R9 probe on 8-bit memory: two pulled-up bits then mem[0][15:2]
    model_al = 8;
    mem[0] = 16'hFFFF;
    op(3'd4, 8'd0, 16'h0, 16'hFFFF, 1, 0, "R9 probe long");
    check(addr_long == 1'b1, "R9 selects long", 32'(addr_long), 1);
    op(3'd1, 8'hA5, 16'h1357, 16'h0, 0, 0, "R9 long write");
    check(last_addr == 32'hA5, "R9 long address", 32'(last_addr), 32'hA5);
    op(3'd0, 8'hA5, 16'h0, 16'h1357, 1, 0, "R9 long read");

    check(seen == pushed, "R12 one response each", 32'(seen), 32'(pushed));
    summary();
  end
endmodule